// File: doc/BRIEF.md
# Strobed Input Capture with Interrupts

This block is the input side of a bus-attached digital I/O module. Twenty-four front-panel lines pass through a two-flop synchroniser. Software can read their present state at any time. A dedicated strobe pin freezes a snapshot of all lines into a capture register and raises a sticky flag, which software polls before it reads the snapshot.

The eight lowest lines can also raise interrupts. For each of these lines a mode bit selects the source. In edge mode, a rising edge on the synchronised line makes the line pending. In strobe mode, a strobe capture that finds the line high makes it pending. Pending bits are gated by per-line enables. The block presents one interrupt request and a vector equal to a programmable base plus the index of the lowest enabled pending line. A single clear register resets both the strobe flag and every pending bit.

Software drives the block through a simple register port with address, write data, write enable and read enable. Read data appears one clock after the read is sampled.

Top module: `strobe_capture_io`

## Requirements
- R1: A read of address 0 returns the synchronised state of the 24 input lines in bits 23:0, with bits 31:24 zero.
- R2: A rising edge on the synchronised strobe, with the strobe flag clear, copies the synchronised input lines into the snapshot register (read at address 1) and sets status bit 0.
- R3: While the strobe flag is set, further strobe edges leave the snapshot unchanged and the flag set.
- R4: A write of any data to address 3 clears the strobe flag and all pending interrupts. A strobe edge in the same cycle still captures, and it leaves the flag set together with any pending bits that the strobe produces.
- R5: A read of address 2 returns the strobe flag in bit 0 and the 3-bit level register (address 7) in bits 6:4, with all other bits zero.
- R6: When bit i of the source-mode register (address 4) is 0, a rising edge on synchronised line i sets pending bit i. The bit stays set until a clear.
- R7: When mode bit i is 1, pending bit i is set only by a strobe capture that finds line i high. Edges on line i alone have no effect.
- R8: The interrupt output is high exactly when some pending line is also enabled in the enable register (address 5, bit i for line i). Writing the complement of a mask disables the lines in that mask.
- R9: While the interrupt output is high, the vector output equals the base register (address 6) plus the index of the lowest enabled pending line. It is 0 otherwise.
- R10: The mode, enable, base and level registers read back their written values, truncated to 8, 8, 8 and 3 bits, one clock after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | 24 | Front-panel input lines |
| strobe_i | input | 1 | Capture strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| irq_vector_o | output | 8 | Interrupt vector |

## Verification
A clear write and a strobe edge can land in the same cycle. Done carelessly, the clear would erase a capture that has just happened. The bench counts synchroniser stages to place the clear write exactly in the cycle where the strobe edge is detected. It then requires status bit 0 to read as set, the snapshot to hold the new line values, and the strobe-mode interrupt to present the correct vector. A separate clear with no strobe present must leave the flag low.

// File: rtl/strobe_capture_io.sv
module strobe_capture_io #(
  parameter int NIN  = 24,
  parameter int NIRQ = 8,
  parameter int VW   = 8,
  parameter int LW   = 3,
  parameter int AW   = 3,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NIN-1:0] pins_i,
  input  logic          strobe_i,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic [VW-1:0] irq_vector_o
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [AW-1:0] A_LIVE = 0, A_SNAP = 1, A_STAT = 2, A_CLR = 3,
                            A_MODE = 4, A_EN = 5, A_BASE = 6, A_LVL = 7;

  logic [NIN-1:0]  pin_m, pin_s, pin_d, snap;
  logic [2:0]      stb_sh;
  logic            flag;
  logic [NIRQ-1:0] mode, en, pending, act, hit;
  logic [VW-1:0]   vbase;
  logic [LW-1:0]   level;
  logic [IW-1:0]   idx;

  wire stb_rise = stb_sh[1] & ~stb_sh[2];
  wire clr_wr   = bus_we && bus_addr == A_CLR;
  wire capture  = stb_rise && (!flag || clr_wr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_m <= '0; pin_s <= '0; pin_d <= '0; stb_sh <= '0;
    end else begin
      pin_m <= pins_i; pin_s <= pin_m; pin_d <= pin_s;
      stb_sh <= {stb_sh[1:0], strobe_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0; snap <= '0;
    end else begin
      flag <= clr_wr ? stb_rise : (flag | stb_rise);
      if (capture) snap <= pin_s;
    end

  assign hit = (mode & ({NIRQ{capture}} & pin_s[NIRQ-1:0]))
             | (~mode & pin_s[NIRQ-1:0] & ~pin_d[NIRQ-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else        pending <= clr_wr ? hit : (pending | hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= '0; en <= '0; vbase <= '0; level <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:  mode  <= bus_wdata[NIRQ-1:0];
        A_EN:    en    <= bus_wdata[NIRQ-1:0];
        A_BASE:  vbase <= bus_wdata[VW-1:0];
        A_LVL:   level <= bus_wdata[LW-1:0];
        default: ;
      endcase
    end

  assign act = pending & en;

  always_comb begin
    idx = '0;
    for (int k = NIRQ - 1; k >= 0; k--)
      if (act[k]) idx = IW'(k);
  end

  assign irq_o        = |act;
  assign irq_vector_o = irq_o ? vbase + VW'(idx) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      case (bus_addr)
        A_LIVE:  bus_rdata <= DW'(pin_s);
        A_SNAP:  bus_rdata <= DW'(snap);
        A_STAT:  bus_rdata <= DW'({level, 3'b000, flag});
        A_MODE:  bus_rdata <= DW'(mode);
        A_EN:    bus_rdata <= DW'(en);
        A_BASE:  bus_rdata <= DW'(vbase);
        A_LVL:   bus_rdata <= DW'(level);
        default: bus_rdata <= '0;
      endcase
    end
endmodule

// File: rtl/strobe_capture_io_chk.sv
module strobe_capture_io_chk #(
  parameter int NIN  = 24,
  parameter int NIRQ = 8,
  parameter int VW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_wr,
  input logic            stb_rise,
  input logic            flag,
  input logic [NIN-1:0]  snap,
  input logic [NIRQ-1:0] pending,
  input logic [NIRQ-1:0] en,
  input logic [VW-1:0]   vbase,
  input logic            irq_o,
  input logic [VW-1:0]   irq_vector_o
);
  logic [VW-1:0]   off;
  logic [NIRQ-1:0] below;
  logic            hit_ok;

  assign off = irq_vector_o - vbase;
  always_comb begin
    below  = '0;
    hit_ok = 1'b0;
    for (int k = 0; k < NIRQ; k++) begin
      if (VW'(k) < off) below[k] = 1'b1;
      if (VW'(k) == off) hit_ok = pending[k] & en[k];
    end
  end

  a_r4_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !stb_rise) |=> !flag);

  a_r3_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> (flag && $stable(snap)));

  a_r6_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pending & $past(pending)) == $past(pending)));

  a_r9_vector_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (hit_ok && ((pending & en & below) == '0)));

  a_r9_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vector_o == '0));
endmodule

bind strobe_capture_io strobe_capture_io_chk #(.NIN(NIN), .NIRQ(NIRQ), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .stb_rise(stb_rise), .flag(flag),
  .snap(snap), .pending(pending), .en(en), .vbase(vbase), .irq_o(irq_o),
  .irq_vector_o(irq_vector_o)
);

// File: tb/tb_strobe_capture_io.sv
`timescale 1ns/1ps
module tb_strobe_capture_io;
  logic        clk = 0, rst_n = 0;
  logic [23:0] pins = '0;
  logic        strobe = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 0, re = 0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;
  int total = 0, bad = 0;
  logic done = 0;

  strobe_capture_io dut (.clk(clk), .rst_n(rst_n), .pins_i(pins), .strobe_i(strobe),
    .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata),
    .irq_o(irq), .irq_vector_o(vec));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1;
    @(posedge clk); @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic settle; repeat (4) @(negedge clk); endtask

  task automatic pulse;
    @(negedge clk); strobe = 1;
    repeat (2) @(negedge clk); strobe = 0;
    settle();
  endtask

  initial begin
    logic [31:0] d;
    logic [23:0] p;
    repeat (3) @(negedge clk); rst_n = 1;
    chk("R9 reset irq", {31'b0, irq}, 0);
    chk("R9 reset vec", {24'b0, vec}, 0);
    rd(2, d); chk("R5 reset status", d, 0);
    rd(1, d); chk("R2 reset snap", d, 0);

    for (int i = 0; i < 24; i++) begin
      pins = 24'(1) << i; settle(); rd(0, d);
      chk("R1 walking one", d, {8'h0, 24'(1) << i});
    end
    for (int i = 0; i < 8; i++) begin
      p = 24'hA5C3F0 ^ (24'h111111 * 24'(i)); pins = p; settle(); rd(0, d);
      chk("R1 pattern", d, {8'h0, p});
    end

    wr(4, 32'hFFFF_FF5A); rd(4, d); chk("R10 mode", d, 32'h5A);
    wr(5, 32'h1234_56C3); rd(5, d); chk("R10 enable", d, 32'hC3);
    wr(6, 32'hDEAD_BE40); rd(6, d); chk("R10 base", d, 32'h40);
    wr(7, 32'hFFFF_FFFF); rd(7, d); chk("R10 level", d, 32'h7);

    wr(4, 0); wr(5, 0); pins = 0; settle();
    wr(7, 5); wr(3, 32'h55); rd(2, d); chk("R5 status level", d, 32'h50);

    pins = 24'h123456; pulse();
    rd(1, d); chk("R2 snapshot", d, 32'h123456);
    rd(2, d); chk("R2 flag set", d, 32'h51);
    pins = 24'hABCDEF; pulse();
    rd(1, d); chk("R3 snapshot held", d, 32'h123456);
    rd(2, d); chk("R3 flag held", d, 32'h51);
    wr(5, 32'hFF);
    wr(3, 0); rd(2, d); chk("R4 flag cleared", d, 32'h50);
    chk("R4 pending cleared", {31'b0, irq}, 0);

    for (int i = 0; i < 8; i++) begin
      pins = 0; settle(); wr(3, 0);
      chk("R6 quiet", {31'b0, irq}, 0);
      pins = 24'(1) << i; settle();
      chk("R6 edge irq", {31'b0, irq}, 1);
      chk("R9 vector", {24'b0, vec}, 32'h40 + i);
      pins = 0; settle();
      chk("R6 sticky", {31'b0, irq}, 1);
    end

    wr(3, 0); pins = 24'hB4; settle();
    chk("R9 priority", {24'b0, vec}, 32'h42);
    wr(5, ~32'h04); chk("R8 complement mask", {24'b0, vec}, 32'h44);
    wr(5, ~32'hB4); chk("R8 all masked", {31'b0, irq}, 0);
    wr(5, 32'hFF); chk("R8 re-enabled", {24'b0, vec}, 32'h42);

    wr(4, 32'hFF); pins = 0; settle(); wr(3, 0);
    pins = 24'h10; settle();
    chk("R7 edge ignored", {31'b0, irq}, 0);
    pins = 24'h18; pulse();
    chk("R7 strobe irq", {24'b0, vec}, 32'h43);
    rd(1, d); chk("R7 snapshot", d, 32'h18);

    wr(3, 0); pins = 24'h06;
    @(negedge clk); strobe = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 3; we = 1;
    @(posedge clk); @(negedge clk); we = 0; strobe = 0;
    settle();
    rd(2, d); chk("R4 collision flag", d, 32'h51);
    rd(1, d); chk("R4 collision snap", d, 32'h06);
    chk("R4 collision vector", {24'b0, vec}, 32'h41);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule